// File: doc/BRIEF.md
# Prescaled Basic Interval Timer

This block is an 8-bit up-counter that runs all the time. It has no stop and no enable. It advances once per period of a prescaler, and the prescaler divides the main oscillator clock by one of eight powers of two, from 16 to 2048. Each time the count wraps from 255 to 0, the block sets a sticky interrupt flag. On the same wrap it emits a one-cycle tick, which a downstream watchdog counter uses as its time base.

Software sees a single register location. A read returns the live count. A write goes to a small control register instead of the counter. That register holds the 3-bit rate select and a self-clearing clear bit, which restarts both the counter and the prescaler. The whole block runs on the oscillator clock. The chosen prescaler tap produces a one-cycle count-enable, so no derived clock is created.

Top module: `bit_timer_top`

## Requirements
- R1: After reset, rd_data is 0, irq_flag is 0 and wdt_tick is 0.
- R2: The count advances by one for every D oscillator cycles, where D = 16 << S and S is the rate select held in wr_data[2:0] of the last write (S = 0 selects divide-by-16, S = 7 selects divide-by-2048).
- R3: The counter cannot be stopped. m cycles after a clear, the count equals floor(m / D) mod 256, so 255 wraps to 0.
- R4: irq_flag goes high on the clock edge at which the count wraps from 255 to 0.
- R5: wdt_tick is high for exactly one cycle for each wrap, in the cycle where the count first reads 0, and is low otherwise.
- R6: irq_flag stays high until irq_ack is sampled high. It is low from the following edge on.
- R7: When irq_ack is sampled on the same edge as a wrap, irq_flag stays high.
- R8: A write with wr_data[3] = 1 zeroes the counter and the prescaler on that edge. When this clear coincides with a wrap, the clear wins: the count is 0, no flag is set and no tick is produced.
- R9: A write with wr_data[3] = 0 changes only the rate select. The count is unchanged, and the new rate applies from the next tap of the running prescaler.
- R10: rd_data always shows the live count, and a write never loads wr_data into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the shared location |
| wr_data | input | 8 | Write data: [2:0] rate select, [3] clear |
| rd_data | output | 8 | Live count value |
| irq_ack | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky overflow interrupt request |
| wdt_tick | output | 1 | One-cycle pulse per overflow for the watchdog |

## Verification
Two pairs of events can land on the same edge. In the first, the counter wraps while irq_ack is high: the bench waits exactly 8191 cycles after a clear, raises irq_ack for the single edge on which the second wrap happens, and then expects the flag to still be set. In the second, a clear write lands on a wrap edge: a clear is issued exactly 4096 cycles after the previous one, and the bench expects a zero count, no flag and no tick.

// File: rtl/bit_timer_pkg.sv
package bit_timer_pkg;
    localparam int CNT_W     = 8;
    localparam int SEL_W     = 3;
    localparam int BASE_LOG2 = 4;
    localparam int NTAPS     = 1 << SEL_W;
    localparam int PRE_W     = BASE_LOG2 + NTAPS - 1;
    localparam int CLR_BIT   = SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             wdt;
    } core_st_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } ctrl_st_t;
endpackage

// File: rtl/bit_prescaler.sv
module bit_prescaler
    import bit_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [NTAPS-1:0] taps;

    // tap i fires when the low BASE_LOG2+i bits of the prescaler are all ones
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        assign taps[i] = &pre_q[BASE_LOG2+i-1:0];
    end

    always_comb begin
        pre_d = clr ? '0 : pre_q + PRE_W'(1);
        step  = taps[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: the smallest divisor is 16, so an enable can never last two cycles
    a_r2_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
endmodule

// File: rtl/bit_count_core.sv
module bit_count_core
    import bit_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clr,
    input  logic             ack,
    output logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             wdt
);
    core_st_t cur_q, nxt_d;
    logic     ovf;

    always_comb begin
        nxt_d = cur_q;
        ovf   = step && (cur_q.cnt == '1) && !clr;
        if (clr)       nxt_d.cnt = '0;
        else if (step) nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        nxt_d.irq = ovf | (cur_q.irq & ~ack);
        nxt_d.wdt = ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt = cur_q.cnt;
    assign irq = cur_q.irq;
    assign wdt = cur_q.wdt;

    // R4 R5: a wrap leaves zero count, flag set and a tick
    a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur_q.cnt == '1 && !clr) |=> (cur_q.cnt == '0 && cur_q.irq && cur_q.wdt));
    // R5: the tick lasts one cycle
    a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.wdt |=> !cur_q.wdt);
    // R6: without an acknowledge the flag holds
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.irq && !ack) |=> cur_q.irq);
    // R3: the count only steps by one or returns to zero
    a_r3_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.cnt) |-> (cur_q.cnt == $past(cur_q.cnt) + CNT_W'(1) || cur_q.cnt == '0));
    // R8: a clear always zeroes the count
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cur_q.cnt == '0 && !cur_q.wdt));
endmodule

// File: rtl/bit_timer_top.sv
module bit_timer_top
    import bit_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_ack,
    output logic             irq_flag,
    output logic             wdt_tick
);
    ctrl_st_t ctrl_q, ctrl_d;
    logic     clr, step;

    always_comb begin
        ctrl_d = ctrl_q;
        clr    = wr_en && wr_data[CLR_BIT];
        if (wr_en) ctrl_d.sel = wr_data[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    bit_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .sel   (ctrl_q.sel),
        .step  (step)
    );

    bit_count_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .clr   (clr),
        .ack   (irq_ack),
        .cnt   (rd_data),
        .irq   (irq_flag),
        .wdt   (wdt_tick)
    );

    // R9 R10: a write without the clear bit leaves the count untouched unless a step occurs
    a_r9_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[CLR_BIT] && !step) |=> $stable(rd_data));
endmodule

// File: tb/tb_bit_timer_top.sv
`timescale 1ns/1ps
module tb_bit_timer_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_ack = 1'b0;
    logic [7:0] rd_data;
    logic       irq_flag, wdt_tick;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bit_timer_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_ack(irq_ack), .irq_flag(irq_flag), .wdt_tick(wdt_tick)
    );

    localparam int NV = 11;
    localparam int V_SEL [NV] = '{0, 0, 0, 1, 2, 3, 4, 5, 6, 7, 7};
    localparam int V_CYC [NV] = '{100, 4095, 4096, 640, 1000, 2560, 2559, 5120, 3072, 6143, 6144};
    localparam int V_CNT [NV] = '{6, 255, 0, 20, 15, 20, 9, 10, 3, 2, 3};
    localparam int V_IRQ [NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ack_pulse;
        irq_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", rd_data, 0);
        check("R1 flag", irq_flag, 0);
        check("R1 tick", wdt_tick, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R10: table of rate / elapsed cycles / expected count and flag
        for (int v = 0; v < NV; v++) begin
            ack_pulse();
            wr(8'(V_SEL[v]) | 8'h08);
            wait_cyc(V_CYC[v]);
            check($sformatf("R2 R3 vec%0d count", v), rd_data, V_CNT[v]);
            check($sformatf("R4 vec%0d flag", v), irq_flag, V_IRQ[v]);
        end

        // R5 tick exactly at the wrap, one cycle wide
        ack_pulse();
        wr(8'h08);
        wait_cyc(4095);
        check("R5 no tick before wrap", wdt_tick, 0);
        wait_cyc(1);
        check("R5 tick at wrap", wdt_tick, 1);
        check("R5 count zero at tick", rd_data, 0);
        wait_cyc(1);
        check("R5 tick drops", wdt_tick, 0);

        // R7 acknowledge on the same edge as a wrap keeps the flag
        ack_pulse();
        wr(8'h08);
        wait_cyc(8191);
        check("R7 flag from first wrap", irq_flag, 1);
        irq_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_ack = 1'b0;
        check("R7 flag kept", irq_flag, 1);
        check("R7 count wrapped", rd_data, 0);
        // R6 acknowledge alone clears
        wait_cyc(5);
        check("R6 flag held", irq_flag, 1);
        ack_pulse();
        check("R6 flag cleared", irq_flag, 0);

        // R8 clear on the wrap edge wins
        wr(8'h08);
        wait_cyc(4095);
        check("R8 count before", rd_data, 255);
        wr(8'h08);
        check("R8 count cleared", rd_data, 0);
        check("R8 no flag", irq_flag, 0);
        check("R8 no tick", wdt_tick, 0);

        // R9 R10 rate change without clear keeps the count
        wr(8'h08);
        wait_cyc(160);
        check("R9 count before", rd_data, 10);
        wr(8'h01);
        check("R10 write keeps count", rd_data, 10);
        wait_cyc(30);
        check("R9 before new tap", rd_data, 10);
        wait_cyc(1);
        check("R9 first new tap", rd_data, 11);
        wait_cyc(32);
        check("R9 second new tap", rd_data, 12);

        finish_run();
    end
endmodule